// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is a single down-counting timer channel that advances once on every rising edge of its clock. Software-facing logic elsewhere hands it a configuration (a 3-bit mode code and a binary/decimal select) and a starting count, each with a one-cycle write strobe. From these it produces a registered output waveform: a terminal-count flag, a one-shot pulse, a periodic divider pulse, a square wave or a single-clock strobe, depending on the mode.

A gate input qualifies counting. In some modes it pauses counting while it is low. In others its rising edge is a trigger. In the divider modes, gate low holds the output high and resets the count. The channel also exposes its live count value and a flag that is set while a written starting count has not yet been moved into the counting register. Counting can run in plain binary or as packed decimal digits. A starting count of zero selects the longest possible run.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `out` is 0, `count` is 0 and `null_cnt` is 1, and nothing counts until a configuration and a count are written.
- R2: Mode codes 6 and 7 behave exactly as codes 2 (rate) and 3 (square wave), because bit 2 of the code is ignored when bit 1 is set.
- R3: Mode 0 (interrupt on terminal count): a configuration write or a count write drives `out` low on the next edge. The count is transferred on the following edge and then decrements once per gated clock. `out` rises on the edge where `count` becomes 0 and stays high while the counter wraps on past zero.
- R4: In modes 0 and 4, while `gate` is low, `count` holds its value. Counting resumes from that value, with no reload, once `gate` is high again.
- R5: Mode 1 (one-shot): a rising edge on `gate` after a count was written loads the count and drives `out` low on that edge. `out` stays low for exactly N clocks. Another rising edge reloads N and lengthens the pulse. A falling edge of `gate` has no effect. A count written during a pulse takes effect only at the next trigger.
- R6: Mode 2 (rate generator), for N of at least 2: the output period is N clocks. `out` is low for exactly one clock, while `count` is 1. On the next edge the count reloads from the stored value, so `count` never reads 0.
- R7: Mode 3 (square wave), for N of at least 2: `out` is high for ceil(N/2) clocks and low for floor(N/2) clocks, starting high at the load. The counter steps by 2.
- R8: In modes 2 and 3, `gate` low drives `out` high on the next edge and stops counting. The first edge that sees `gate` high again reloads the full starting count, with `out` high.
- R9: Mode 4 (software strobe): `out` is high after configuration. It goes low for exactly one clock on the edge where `count` reaches 0, then returns high. It pulses only once per written count, even when the counter wraps.
- R10: Mode 5 (hardware strobe): counting starts on a `gate` rising edge and ignores the gate level afterwards. `out` gives the same single-clock low pulse at zero. A later rising edge restarts the count from the stored value.
- R11: With `cfg_bcd` = 1, the count is held as WIDTH/4 packed decimal digits (4 bits per digit, least significant digit in bits 3:0) and decrements in decimal. For example, 0x10 steps to 0x09 when stepping by 1, and to 0x08 when stepping by 2.
- R12: A starting count of 0 gives the maximum run: 2^WIDTH clocks in binary, or 10^(WIDTH/4) clocks in decimal.
- R13: `null_cnt` is set on the edge of any configuration or count write. It is cleared on the edge where the stored count is transferred into the counter (the load, trigger or reload for the mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; everything advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | One-cycle strobe that writes the mode and number format and resets the channel state |
| cfg_mode | input | 3 | Mode code: 0 terminal count, 1 one-shot, 2 rate, 3 square, 4 software strobe, 5 hardware strobe, 6/7 alias 2/3 |
| cfg_bcd | input | 1 | 1 selects decimal counting, 0 binary |
| cnt_we | input | 1 | One-cycle strobe that stores a new starting count |
| cnt_val | input | WIDTH | Starting count value |
| gate | input | 1 | Gate: level enable, trigger or force, depending on mode |
| out | output | 1 | Registered timer output |
| count | output | WIDTH | Live counter value |
| null_cnt | output | 1 | High while a written count has not yet been moved into the counter |

## Verification
The bench builds the channel with WIDTH = 8, which gives two decimal digits. With that width, the zero-means-maximum cases take 256 binary or 100 decimal clocks, and a complete wrap past zero is short enough to watch, so the single-pulse limit of the strobe modes can be checked. The narrow width also keeps odd and even square-wave periods, the decimal borrow across digits and the gate restart of the divider modes to a few dozen cycles each. The logic is the same at the default width, since only the digit count and the count width change.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [2:0] {
    M_TCINT    = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } tmr_mode_e;

  // Codes with bit 1 set fold onto the divider modes regardless of bit 2.
  function automatic tmr_mode_e fold_mode(input logic [2:0] code);
    if (code[1]) return tmr_mode_e'({1'b0, code[1:0]});
    else         return tmr_mode_e'(code);
  endfunction

endpackage

// File: rtl/tmr_dec.sv
`timescale 1ns/1ps
// Subtracts 1 or 2 from the count, in binary or packed-decimal form.
module tmr_dec #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] val,
  input  logic             bcd,
  input  logic             two,
  output logic [WIDTH-1:0] res
);
  localparam int DIGITS = WIDTH / 4;

  logic [WIDTH-1:0]  bin_res;
  logic [WIDTH-1:0]  dec_res;
  logic [DIGITS-1:0] brw;

  assign bin_res = val - {{(WIDTH-2){1'b0}}, two, ~two};
  assign brw[0]  = ~two;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig;
    logic [3:0] amt;
    assign dig = val[4*g +: 4];
    assign amt = {2'b00, (g == 0) ? two : 1'b0, brw[g]};
    assign dec_res[4*g +: 4] = (dig >= amt) ? dig - amt : dig + 4'd10 - amt;
    if (g < DIGITS - 1) begin : g_borrow
      assign brw[g+1] = (dig < amt);
    end
  end

  assign res = bcd ? dec_res : bin_res;

endmodule

// File: rtl/tmr_gate_edge.sv
`timescale 1ns/1ps
// Registers the gate once and flags a low-to-high transition.
module tmr_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate;
  end

  assign rise = gate & ~gate_q;

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_bcd,
  input  logic             cnt_we,
  input  logic [WIDTH-1:0] cnt_val,
  input  logic             gate,
  output logic             out,
  output logic [WIDTH-1:0] count,
  output logic             null_cnt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] TWO = WIDTH'(2);

  tmr_mode_e        mode_r;
  logic             bcd_r;
  logic [WIDTH-1:0] init_r;
  logic [WIDTH-1:0] cnt_r;
  logic             out_r;
  logic             null_r;
  logic             have_init;
  logic             need_load;
  logic             run_r;
  logic             fired_r;
  logic             odd_r;

  logic [WIDTH-1:0] cnt_dec;
  logic [WIDTH-1:0] sq_load;
  logic             sq_term;
  logic             rise;

  tmr_dec #(.WIDTH(WIDTH)) u_dec (
    .val (cnt_r),
    .bcd (bcd_r),
    .two (mode_r == M_SQUARE),
    .res (cnt_dec)
  );

  tmr_gate_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .gate (gate),
    .rise (rise)
  );

  // Square wave: even reload value; an odd count extends the high half
  // by letting it run down to zero instead of stopping at two.
  assign sq_load = {init_r[WIDTH-1:1], 1'b0};
  assign sq_term = (out_r && odd_r) ? (cnt_r == '0) : (cnt_r == TWO);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r    <= M_TCINT;
      bcd_r     <= 1'b0;
      init_r    <= '0;
      cnt_r     <= '0;
      out_r     <= 1'b0;
      null_r    <= 1'b1;
      have_init <= 1'b0;
      need_load <= 1'b0;
      run_r     <= 1'b0;
      fired_r   <= 1'b1;
      odd_r     <= 1'b0;
    end else if (cfg_we) begin
      mode_r    <= fold_mode(cfg_mode);
      bcd_r     <= cfg_bcd;
      out_r     <= (fold_mode(cfg_mode) != M_TCINT);
      null_r    <= 1'b1;
      have_init <= 1'b0;
      need_load <= 1'b0;
      run_r     <= 1'b0;
      fired_r   <= 1'b1;
    end else begin
      case (mode_r)
        M_TCINT, M_SWSTROBE: begin
          if (mode_r == M_SWSTROBE && !out_r) out_r <= 1'b1;
          if (need_load) begin
            cnt_r     <= init_r;
            null_r    <= 1'b0;
            need_load <= 1'b0;
            run_r     <= 1'b1;
            fired_r   <= 1'b0;
          end else if (run_r && gate) begin
            cnt_r <= cnt_dec;
            if (cnt_r == ONE && !fired_r) begin
              fired_r <= 1'b1;
              out_r   <= (mode_r == M_TCINT);
            end
          end
        end
        M_ONESHOT, M_HWSTROBE: begin
          if (mode_r == M_HWSTROBE && !out_r) out_r <= 1'b1;
          if (rise && have_init) begin
            cnt_r   <= init_r;
            null_r  <= 1'b0;
            run_r   <= 1'b1;
            fired_r <= 1'b0;
            if (mode_r == M_ONESHOT) out_r <= 1'b0;
          end else if (run_r) begin
            cnt_r <= cnt_dec;
            if (cnt_r == ONE && !fired_r) begin
              fired_r <= 1'b1;
              out_r   <= (mode_r == M_ONESHOT);
            end
          end
        end
        M_RATE, M_SQUARE: begin
          if (!gate) begin
            out_r <= 1'b1;
            run_r <= 1'b0;
            if (have_init) need_load <= 1'b1;
          end else if (need_load) begin
            cnt_r     <= (mode_r == M_SQUARE) ? sq_load : init_r;
            odd_r     <= init_r[0];
            out_r     <= 1'b1;
            null_r    <= 1'b0;
            run_r     <= 1'b1;
            need_load <= 1'b0;
          end else if (run_r) begin
            if (mode_r == M_RATE) begin
              if (cnt_r == ONE) begin
                cnt_r  <= init_r;
                null_r <= 1'b0;
                out_r  <= 1'b1;
              end else begin
                cnt_r <= cnt_dec;
                out_r <= (cnt_r != TWO);
              end
            end else if (sq_term) begin
              cnt_r  <= sq_load;
              odd_r  <= init_r[0];
              out_r  <= ~out_r;
              null_r <= 1'b0;
            end else begin
              cnt_r <= cnt_dec;
            end
          end
        end
        default: ;
      endcase

      // A count write takes priority over the mode action in the same cycle.
      if (cnt_we) begin
        init_r    <= cnt_val;
        null_r    <= 1'b1;
        have_init <= 1'b1;
        if (mode_r == M_TCINT || mode_r == M_SWSTROBE) begin
          need_load <= 1'b1;
          run_r     <= 1'b0;
          if (mode_r == M_TCINT) out_r <= 1'b0;
        end else if ((mode_r == M_RATE || mode_r == M_SQUARE) && !have_init) begin
          need_load <= 1'b1;
        end
      end
    end
  end

  assign out      = out_r;
  assign count    = cnt_r;
  assign null_cnt = null_r;

endmodule

// File: rtl/tmr_channel_chk.sv
`timescale 1ns/1ps
module tmr_channel_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [2:0]       cfg_mode,
  input logic             cnt_we,
  input logic             gate,
  input logic             out,
  input logic [WIDTH-1:0] count,
  input logic             null_cnt,
  input logic [2:0]       mode
);

  // R3
  tc_low_on_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_mode == 3'd0) |=> !out);

  // R4
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd0 || mode == 3'd4) && !gate && !null_cnt && !cfg_we && !cnt_we)
      |=> $stable(count));

  // R8
  div_gate_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd2 || mode == 3'd3) && !gate && !cfg_we) |=> out);

  // R9
  strobe_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd4 || mode == 3'd5) && !out && !cfg_we) |=> out);

  // R13
  null_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we || cnt_we) |=> null_cnt);

endmodule

bind tmr_channel tmr_channel_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_mode (cfg_mode),
  .cnt_we   (cnt_we),
  .gate     (gate),
  .out      (out),
  .count    (count),
  .null_cnt (null_cnt),
  .mode     (mode_r)
);

// File: tb/sim_tmr_channel.sv
`timescale 1ns/1ps
module sim_tmr_channel;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_mode = 3'd0;
  logic         cfg_bcd = 1'b0;
  logic         cnt_we = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         gate = 1'b0;
  logic         out;
  logic [W-1:0] count;
  logic         null_cnt;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_channel #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
    .cnt_we(cnt_we), .cnt_val(cnt_val), .gate(gate),
    .out(out), .count(count), .null_cnt(null_cnt)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] m, input logic b);
    cfg_mode = m; cfg_bcd = b; cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [W-1:0] v);
    cnt_val = v; cnt_we = 1'b1;
    step();
    cnt_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "out", out, 0);
    chk("R1", "count", count, 0);
    chk("R1", "null_cnt", null_cnt, 1);
    step(3);
    chk("R1", "count idle", count, 0);
  endtask

  task automatic t_mode0();
    gate = 1'b1;
    wr_cfg(3'd0, 1'b0);
    chk("R3", "out after cfg", out, 0);
    chk("R13", "null after cfg", null_cnt, 1);
    wr_cnt(8'd5);
    chk("R3", "out after write", out, 0);
    step();
    chk("R3", "loaded count", count, 5);
    chk("R13", "null after load", null_cnt, 0);
    step(4);
    chk("R3", "count at 1", count, 1);
    chk("R3", "out before zero", out, 0);
    step();
    chk("R3", "out at zero", out, 1);
    step();
    chk("R3", "wrapped count", count, 255);
    chk("R3", "out after wrap", out, 1);
  endtask

  task automatic t_pause();
    gate = 1'b1;
    wr_cfg(3'd0, 1'b0);
    wr_cnt(8'd10);
    step(2);
    chk("R4", "count before pause", count, 9);
    gate = 1'b0;
    step(3);
    chk("R4", "count held", count, 9);
    gate = 1'b1;
    step();
    chk("R4", "count resumed", count, 8);
  endtask

  task automatic t_mode4();
    int lows = 0;
    gate = 1'b1;
    wr_cfg(3'd4, 1'b0);
    chk("R9", "out after cfg", out, 1);
    wr_cnt(8'd3);
    step(3);
    chk("R9", "count at 1", count, 1);
    chk("R9", "out before zero", out, 1);
    step();
    chk("R9", "strobe low", out, 0);
    step();
    chk("R9", "strobe back high", out, 1);
    for (int i = 0; i < 300; i++) begin
      step();
      if (!out) lows++;
    end
    chk("R9", "no second strobe", lows, 0);
  endtask

  task automatic t_mode1();
    int lows = 0;
    gate = 1'b0;
    wr_cfg(3'd1, 1'b0);
    chk("R5", "out after cfg", out, 1);
    wr_cnt(8'd4);
    step(3);
    chk("R13", "null before trigger", null_cnt, 1);
    chk("R5", "out before trigger", out, 1);
    gate = 1'b1;
    step();
    chk("R5", "count at trigger", count, 4);
    chk("R5", "out at trigger", out, 0);
    chk("R13", "null after trigger", null_cnt, 0);
    step(3);
    chk("R5", "out still low", out, 0);
    step();
    chk("R5", "out after N clocks", out, 1);
    gate = 1'b0; step(); gate = 1'b1; step();
    chk("R5", "second trigger low", out, 0);
    step(2);
    wr_cnt(8'd7);
    chk("R5", "out low after mid write", out, 0);
    step();
    chk("R5", "pulse ends with old count", out, 1);
    gate = 1'b0; step(); gate = 1'b1; step();
    chk("R5", "new count at trigger", count, 7);
    step(2);
    gate = 1'b0;
    step();
    chk("R5", "gate fall ignored", count, 4);
    chk("R5", "gate fall out", out, 0);
    gate = 1'b1;
    step();
    chk("R5", "retrigger reload", count, 7);
    for (int i = 0; i < 10; i++) begin
      if (!out) lows++;
      step();
    end
    chk("R5", "retriggered pulse length", lows, 7);
  endtask

  task automatic t_mode2(input logic [2:0] code);
    int lows = 0, zeros = 0, bad = 0;
    string rq;
    rq = (code == 3'd6) ? "R2" : "R6";
    gate = 1'b1;
    wr_cfg(code, 1'b0);
    wr_cnt(8'd4);
    step();
    chk(rq, "loaded count", count, 4);
    for (int i = 0; i < 12; i++) begin
      step();
      if (!out) lows++;
      if (count == 0) zeros++;
      if (!out && count != 1) bad++;
    end
    chk(rq, "low pulses in 3 periods", lows, 3);
    chk(rq, "count never zero", zeros, 0);
    chk(rq, "low only at count 1", bad, 0);
    wr_cnt(8'd3);
    chk("R13", "null after mid write", null_cnt, 1);
    step(3);
    chk("R13", "null after reload", null_cnt, 0);
    chk("R6", "new count at reload", count, 3);
  endtask

  task automatic t_gate_div();
    gate = 1'b1;
    wr_cfg(3'd2, 1'b0);
    wr_cnt(8'd3);
    step(3);
    chk("R8", "out low at count 1", out, 0);
    gate = 1'b0;
    step();
    chk("R8", "gate low forces out", out, 1);
    step(2);
    gate = 1'b1;
    step();
    chk("R8", "restart count", count, 3);
    chk("R8", "restart out", out, 1);
    step(2);
    chk("R8", "restart low at 1", out, 0);
  endtask

  task automatic t_mode3(input logic [2:0] code, input int n);
    int hi = 0;
    int hlen;
    string rq;
    hlen = (n + 1) / 2;
    rq = (code == 3'd7) ? "R2" : "R7";
    gate = 1'b1;
    wr_cfg(code, 1'b0);
    wr_cnt(W'(n));
    step();
    for (int i = 0; i < 2 * n; i++) begin
      if (out) hi++;
      if (i == hlen - 1) chk(rq, "last high clock", out, 1);
      if (i == hlen) chk(rq, "first low clock", out, 0);
      step();
    end
    chk("R7", "high clocks in 2 periods", hi, 2 * hlen);
  endtask

  task automatic t_mode5();
    gate = 1'b0;
    wr_cfg(3'd5, 1'b0);
    wr_cnt(8'd3);
    step(2);
    chk("R10", "out before trigger", out, 1);
    chk("R13", "null before trigger", null_cnt, 1);
    gate = 1'b1;
    step();
    chk("R10", "count at trigger", count, 3);
    chk("R10", "out at trigger", out, 1);
    step(2);
    gate = 1'b0;
    step();
    chk("R10", "strobe low", out, 0);
    step();
    chk("R10", "strobe back high", out, 1);
    gate = 1'b1;
    step();
    chk("R10", "retrigger count", count, 3);
    step(3);
    chk("R10", "second strobe", out, 0);
  endtask

  task automatic t_bcd();
    gate = 1'b1;
    wr_cfg(3'd0, 1'b1);
    wr_cnt(8'h10);
    step();
    chk("R11", "loaded 0x10", count, 8'h10);
    step();
    chk("R11", "decimal borrow", count, 8'h09);
    wr_cfg(3'd3, 1'b1);
    wr_cnt(8'h10);
    step();
    chk("R11", "square load", count, 8'h10);
    step();
    chk("R11", "decimal step by 2", count, 8'h08);
  endtask

  task automatic t_max();
    int n = 0;
    gate = 1'b1;
    wr_cfg(3'd0, 1'b0);
    wr_cnt(8'd0);
    step();
    do begin step(); n++; end while (!out && n < 400);
    chk("R12", "binary max run", n, 256);
    wr_cfg(3'd0, 1'b1);
    wr_cnt(8'd0);
    step(2);
    chk("R12", "decimal wrap to 99", count, 8'h99);
    n = 1;
    do begin step(); n++; end while (!out && n < 400);
    chk("R12", "decimal max run", n, 100);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    t_reset();
    t_mode0();
    t_pause();
    t_mode4();
    t_mode1();
    t_mode2(3'd2);
    t_mode2(3'd6);
    t_gate_div();
    t_mode3(3'd3, 4);
    t_mode3(3'd7, 5);
    t_mode3(3'd3, 2);
    t_mode5();
    t_bcd();
    t_max();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(10 * 20000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule